// File: doc/BRIEF.md
# Non-Blocking Miss Request Buffer

This block sits beside a data cache and keeps track of line reads that have gone to memory but not yet come back, so the cache can go on serving hits and accept more misses meanwhile. Each tracked line has one entry: the line address plus four word slots. Each slot carries a valid bit and the processor's request tag for that word.

A load miss to a line with no entry claims the lowest-numbered free entry. It records its tag in the slot for the missed word and sends one line read to the memory scheduler, labelled with the entry index. A later load miss to the same line only fills in its word slot and sends nothing. A store is compared against every entry and is held back while a read of its line is outstanding. When a whole line comes back with its entry index, the block hands one word per cycle to the processor for every valid slot, in ascending word order, each with its recorded tag. After the last word it frees the entry.

Top module: `miss_merge_buf`

## Requirements
- R1: After reset all entries are free, and with all inputs idle `mem_req_valid`, `resp_valid`, `ld_stall` and `st_stall` are low.
- R2: A load miss whose line matches no entry is accepted if any entry is free. It takes the lowest-numbered free entry, and on the next clock edge `mem_req_valid` pulses for one cycle with `mem_req_line` equal to the load's line and `mem_req_id` equal to that entry index.
- R3: A load miss whose line matches an existing entry, and whose word slot is empty, is accepted into that slot and produces no memory request.
- R4: A fill on `fill_valid` with index `fill_id` is captured on a clock edge. Starting at the next edge, one response per cycle appears on `resp_valid`, one for each valid slot of that entry. Each response carries the slot's tag on `resp_ptag`, the word number on `resp_word`, and `fill_data[resp_word*DATA_W +: DATA_W]` on `resp_data`. Nothing more is produced for that fill.
- R5: The responses of one fill come out in strictly ascending word number (0 to 3), on consecutive cycles.
- R6: The edge that delivers the last response frees the entry. From then on a store to that line is not stalled, and the entry index can be allocated again.
- R7: `st_stall` is high in the same cycle as `st_valid` exactly when some entry, including one being delivered, holds the store's line.
- R8: When no entry is free, a load miss to an untracked line is stalled (`ld_stall` high in the same cycle) and sends no request. A load to a tracked line is still accepted. `ld_stall` is never high without `ld_valid`.
- R9: A load to a tracked line whose word slot is already valid is stalled and changes nothing.
- R10: A load whose line matches the entry currently being delivered is stalled and produces no request.
- R11: The number of entries is the parameter `ENTRIES`. Memory indexes run from 0 to `ENTRIES-1`, and `fill_id` alone selects which entry's slots are answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_valid | input | 1 | Load miss presented |
| ld_line | input | LINE_AW | Line address of the load miss |
| ld_word | input | 2 | Word within the line |
| ld_ptag | input | PTAG_W | Processor request tag |
| ld_stall | output | 1 | Load not accepted this cycle |
| mem_req_valid | output | 1 | One-cycle line read request |
| mem_req_line | output | LINE_AW | Line address to read |
| mem_req_id | output | ID_W | Entry index used as memory tag |
| st_valid | input | 1 | Store presented |
| st_line | input | LINE_AW | Line address of the store |
| st_stall | output | 1 | Store must wait |
| fill_valid | input | 1 | Line data returned |
| fill_id | input | ID_W | Entry index of the returned line |
| fill_data | input | 4*DATA_W | Four returned words, word 0 lowest |
| resp_valid | output | 1 | Word returned to processor |
| resp_ptag | output | PTAG_W | Tag of the answered request |
| resp_data | output | DATA_W | Returned word |
| resp_word | output | 2 | Word number of the response |

## Verification
The checks assume that a fill arrives only when no earlier fill is still being handed out, and that `fill_id` names an entry with a request in flight. The stimulus keeps to this by waiting out each delivery burst before presenting the next fill, and by filling only indexes that were seen on `mem_req_id`. Loads and stores are presented in separate cycles, and each one is held for exactly one cycle whether it stalls or not. The rule that slot order only rises therefore never spans two fills.

// File: rtl/mmb_pkg.sv
package mmb_pkg;
   // Words per cache line; slot selection and response order depend on it.
   localparam int unsigned LINE_WORDS = 4;
   localparam int unsigned WSEL_W     = $clog2(LINE_WORDS);
   typedef logic [LINE_WORDS-1:0] slot_mask_t;
endpackage

// File: rtl/mmb_pick.sv
// Lowest-index priority pick over a request vector.
module mmb_pick #(
   parameter  int unsigned N  = 4,
   localparam int unsigned IW = $clog2(N)
) (
   input  logic [N-1:0]  req,
   output logic          found,
   output logic [IW-1:0] idx
);
   if (N < 2) begin : g_bad_n
      $error("mmb_pick: N must be at least 2");
   end

   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      end
   end
endmodule

// File: rtl/mmb_match.sv
// Fully associative single-cycle line compare across all entries.
module mmb_match #(
   parameter  int unsigned N  = 4,
   parameter  int unsigned AW = 16,
   localparam int unsigned IW = $clog2(N)
) (
   input  logic [N-1:0]         ent_valid,
   input  logic [N-1:0][AW-1:0] ent_line,
   input  logic [AW-1:0]        key,
   output logic [N-1:0]         hit,
   output logic                 hit_any,
   output logic [IW-1:0]        hit_idx
);
   for (genvar e = 0; e < N; e++) begin : g_cmp
      assign hit[e] = ent_valid[e] && (ent_line[e] == key);
   end

   mmb_pick #(.N(N)) u_pick (
      .req   (hit),
      .found (hit_any),
      .idx   (hit_idx)
   );
endmodule

// File: rtl/miss_merge_buf.sv
module miss_merge_buf
   import mmb_pkg::*;
#(
   parameter int unsigned ENTRIES = 4,
   parameter int unsigned LINE_AW = 16,
   parameter int unsigned PTAG_W  = 6,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ID_W    = $clog2(ENTRIES)
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         ld_valid,
   input  logic [LINE_AW-1:0]           ld_line,
   input  logic [WSEL_W-1:0]            ld_word,
   input  logic [PTAG_W-1:0]            ld_ptag,
   output logic                         ld_stall,
   output logic                         mem_req_valid,
   output logic [LINE_AW-1:0]           mem_req_line,
   output logic [ID_W-1:0]              mem_req_id,
   input  logic                         st_valid,
   input  logic [LINE_AW-1:0]           st_line,
   output logic                         st_stall,
   input  logic                         fill_valid,
   input  logic [ID_W-1:0]              fill_id,
   input  logic [LINE_WORDS*DATA_W-1:0] fill_data,
   output logic                         resp_valid,
   output logic [PTAG_W-1:0]            resp_ptag,
   output logic [DATA_W-1:0]            resp_data,
   output logic [WSEL_W-1:0]            resp_word
);
   localparam int unsigned LINE_BITS = LINE_WORDS * DATA_W;

   if (ENTRIES < 2) begin : g_bad_entries
      $error("miss_merge_buf: ENTRIES must be at least 2");
   end
   if (ID_W != $clog2(ENTRIES)) begin : g_bad_idw
      $error("miss_merge_buf: ID_W must equal clog2(ENTRIES)");
   end
   if (LINE_AW == 0 || PTAG_W == 0 || DATA_W == 0) begin : g_bad_width
      $error("miss_merge_buf: widths must be nonzero");
   end

   // Entry storage
   logic [ENTRIES-1:0]                               ent_valid;
   logic [ENTRIES-1:0][LINE_AW-1:0]                  ent_line;
   logic [ENTRIES-1:0][LINE_WORDS-1:0]               slot_vld;
   logic [ENTRIES-1:0][LINE_WORDS-1:0][PTAG_W-1:0]   slot_tag;

   // Delivery state
   logic                  drain_busy;
   logic [ID_W-1:0]       drain_id;
   logic [LINE_BITS-1:0]  drain_data;

   // Lookups
   logic [ENTRIES-1:0] ld_hit, st_hit;
   logic               ld_hit_any, st_hit_any;
   logic [ID_W-1:0]    ld_hit_idx, st_hit_idx;
   logic               free_any;
   logic [ID_W-1:0]    free_idx;

   mmb_match #(.N(ENTRIES), .AW(LINE_AW)) u_ld_match (
      .ent_valid (ent_valid),
      .ent_line  (ent_line),
      .key       (ld_line),
      .hit       (ld_hit),
      .hit_any   (ld_hit_any),
      .hit_idx   (ld_hit_idx)
   );

   mmb_match #(.N(ENTRIES), .AW(LINE_AW)) u_st_match (
      .ent_valid (ent_valid),
      .ent_line  (ent_line),
      .key       (st_line),
      .hit       (st_hit),
      .hit_any   (st_hit_any),
      .hit_idx   (st_hit_idx)
   );

   mmb_pick #(.N(ENTRIES)) u_free (
      .req   (~ent_valid),
      .found (free_any),
      .idx   (free_idx)
   );

   // Load acceptance
   logic hit_draining, slot_taken, ld_take, ld_alloc, ld_merge;

   assign hit_draining = drain_busy && (ld_hit_idx == drain_id);
   assign slot_taken   = slot_vld[ld_hit_idx][ld_word];
   assign ld_stall     = ld_valid && (ld_hit_any ? (hit_draining || slot_taken) : !free_any);
   assign ld_take      = ld_valid && !ld_stall;
   assign ld_alloc     = ld_take && !ld_hit_any;
   assign ld_merge     = ld_take && ld_hit_any;
   assign st_stall     = st_valid && st_hit_any;

   // Slot selection during delivery
   slot_mask_t        cur_mask;
   logic              pick_found;
   logic [WSEL_W-1:0] pick_idx;
   logic              drain_last;

   assign cur_mask = slot_vld[drain_id];

   mmb_pick #(.N(LINE_WORDS)) u_slot (
      .req   (cur_mask),
      .found (pick_found),
      .idx   (pick_idx)
   );

   assign drain_last = (cur_mask & ~(slot_mask_t'(1) << pick_idx)) == '0;

   // Control state with reset
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ent_valid     <= '0;
         slot_vld      <= '0;
         drain_busy    <= 1'b0;
         drain_id      <= '0;
         resp_valid    <= 1'b0;
         mem_req_valid <= 1'b0;
      end else begin
         mem_req_valid <= ld_alloc;
         resp_valid    <= drain_busy && pick_found;
         if (ld_alloc) begin
            ent_valid[free_idx] <= 1'b1;
            slot_vld[free_idx]  <= slot_mask_t'(1) << ld_word;
         end
         if (ld_merge) begin
            slot_vld[ld_hit_idx][ld_word] <= 1'b1;
         end
         if (drain_busy) begin
            slot_vld[drain_id][pick_idx] <= 1'b0;
            if (drain_last) begin
               ent_valid[drain_id] <= 1'b0;
               slot_vld[drain_id]  <= '0;
               drain_busy          <= 1'b0;
            end
         end
         if (fill_valid) begin
            drain_busy <= 1'b1;
            drain_id   <= fill_id;
         end
      end
   end

   // Payload state without reset
   always_ff @(posedge clk) begin
      if (ld_alloc) begin
         ent_line[free_idx]          <= ld_line;
         slot_tag[free_idx][ld_word] <= ld_ptag;
         mem_req_line                <= ld_line;
         mem_req_id                  <= free_idx;
      end
      if (ld_merge) begin
         slot_tag[ld_hit_idx][ld_word] <= ld_ptag;
      end
      if (fill_valid) begin
         drain_data <= fill_data;
      end
      if (drain_busy) begin
         resp_ptag <= slot_tag[drain_id][pick_idx];
         resp_data <= drain_data[pick_idx*DATA_W +: DATA_W];
         resp_word <= pick_idx;
      end
   end
endmodule

// File: rtl/mmb_checker.sv
module mmb_checker
   import mmb_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              ld_valid,
   input logic              ld_stall,
   input logic              ld_hit_any,
   input logic              mem_req_valid,
   input logic              st_valid,
   input logic              st_stall,
   input logic              fill_valid,
   input logic              drain_busy,
   input logic              resp_valid,
   input logic [WSEL_W-1:0] resp_word
);
   p_stall_needs_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_valid |-> !ld_stall);

   p_primary_issues_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && !ld_stall && !ld_hit_any) |=> mem_req_valid);

   p_req_from_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> $past(ld_valid));

   p_merge_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && !ld_stall && ld_hit_any) |=> !mem_req_valid);

   p_fill_answers_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid |=> ##1 resp_valid);

   // R4 input assumption: a fill never overlaps a delivery in progress
   p_fill_spaced_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid |-> !drain_busy);

   p_slot_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && $past(resp_valid)) |-> (resp_word > $past(resp_word)));

   p_store_stall_needs_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !st_valid |-> !st_stall);
endmodule

bind miss_merge_buf mmb_checker u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .ld_valid      (ld_valid),
   .ld_stall      (ld_stall),
   .ld_hit_any    (ld_hit_any),
   .mem_req_valid (mem_req_valid),
   .st_valid      (st_valid),
   .st_stall      (st_stall),
   .fill_valid    (fill_valid),
   .drain_busy    (drain_busy),
   .resp_valid    (resp_valid),
   .resp_word     (resp_word)
);

// File: tb/sim_miss_merge_buf.sv
module sim_miss_merge_buf;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int unsigned ENTRIES = 4;
   localparam int unsigned LINE_AW = 16;
   localparam int unsigned PTAG_W  = 6;
   localparam int unsigned DATA_W  = 32;
   localparam int unsigned ID_W    = 2;

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic                  ld_valid = 1'b0;
   logic [LINE_AW-1:0]    ld_line = '0;
   logic [1:0]            ld_word = '0;
   logic [PTAG_W-1:0]     ld_ptag = '0;
   logic                  ld_stall;
   logic                  mem_req_valid;
   logic [LINE_AW-1:0]    mem_req_line;
   logic [ID_W-1:0]       mem_req_id;
   logic                  st_valid = 1'b0;
   logic [LINE_AW-1:0]    st_line = '0;
   logic                  st_stall;
   logic                  fill_valid = 1'b0;
   logic [ID_W-1:0]       fill_id = '0;
   logic [4*DATA_W-1:0]   fill_data = '0;
   logic                  resp_valid;
   logic [PTAG_W-1:0]     resp_ptag;
   logic [DATA_W-1:0]     resp_data;
   logic [1:0]            resp_word;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   miss_merge_buf #(
      .ENTRIES (ENTRIES), .LINE_AW (LINE_AW), .PTAG_W (PTAG_W),
      .DATA_W (DATA_W), .ID_W (ID_W)
   ) u0 (
      .clk (clk), .rst_n (rst_n),
      .ld_valid (ld_valid), .ld_line (ld_line), .ld_word (ld_word),
      .ld_ptag (ld_ptag), .ld_stall (ld_stall),
      .mem_req_valid (mem_req_valid), .mem_req_line (mem_req_line),
      .mem_req_id (mem_req_id),
      .st_valid (st_valid), .st_line (st_line), .st_stall (st_stall),
      .fill_valid (fill_valid), .fill_id (fill_id), .fill_data (fill_data),
      .resp_valid (resp_valid), .resp_ptag (resp_ptag),
      .resp_data (resp_data), .resp_word (resp_word)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle_inputs();
      ld_valid = 1'b0; st_valid = 1'b0; fill_valid = 1'b0;
   endtask

   // Present a fill for one cycle, leaving the clock at the negedge after capture
   task automatic send_fill(input logic [ID_W-1:0] id, input logic [31:0] base);
      fill_valid = 1'b1;
      fill_id    = id;
      for (int w = 0; w < 4; w++) fill_data[w*DATA_W +: DATA_W] = base + 32'(w);
      @(negedge clk);
      fill_valid = 1'b0;
   endtask

   task automatic expect_resp(input string req, input logic [1:0] w,
                              input logic [PTAG_W-1:0] tag, input logic [31:0] base);
      chk(resp_valid == 1'b1, req, 64'(resp_valid), 64'd1);
      chk(resp_word == w, req, 64'(resp_word), 64'(w));
      chk(resp_ptag == tag, req, 64'(resp_ptag), 64'(tag));
      chk(resp_data == base + 32'(w), req, 64'(resp_data), 64'(base + 32'(w)));
   endtask

   // kind: 1 = load, 2 = store
   typedef struct packed {
      logic [1:0]  kind;
      logic [15:0] line;
      logic [1:0]  word;
      logic [5:0]  tag;
      logic        stall;
      logic        req;
      logic [1:0]  id;
   } vec_t;

   localparam int NVEC = 10;
   localparam vec_t TBL [NVEC] = '{
      '{2'd1, 16'h0100, 2'd1, 6'd1, 1'b0, 1'b1, 2'd0},  // R2 primary, entry 0
      '{2'd1, 16'h0100, 2'd3, 6'd2, 1'b0, 1'b0, 2'd0},  // R3 merge
      '{2'd1, 16'h0100, 2'd1, 6'd3, 1'b1, 1'b0, 2'd0},  // R9 slot taken
      '{2'd2, 16'h0100, 2'd0, 6'd0, 1'b1, 1'b0, 2'd0},  // R7 pending line
      '{2'd2, 16'h0200, 2'd0, 6'd0, 1'b0, 1'b0, 2'd0},  // R7 other line
      '{2'd1, 16'h0200, 2'd0, 6'd4, 1'b0, 1'b1, 2'd1},  // R2 entry 1
      '{2'd1, 16'h0300, 2'd2, 6'd5, 1'b0, 1'b1, 2'd2},  // R2 entry 2
      '{2'd1, 16'h0400, 2'd0, 6'd6, 1'b0, 1'b1, 2'd3},  // R11 last index
      '{2'd1, 16'h0500, 2'd0, 6'd7, 1'b1, 1'b0, 2'd0},  // R8 full
      '{2'd1, 16'h0300, 2'd0, 6'd8, 1'b0, 1'b0, 2'd0}   // R8 merge while full
   };

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      idle_inputs();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(mem_req_valid == 1'b0, "R1 mem_req_valid", 64'(mem_req_valid), 64'd0);
      chk(resp_valid == 1'b0, "R1 resp_valid", 64'(resp_valid), 64'd0);
      chk(ld_stall == 1'b0, "R1 ld_stall", 64'(ld_stall), 64'd0);
      chk(st_stall == 1'b0, "R1 st_stall", 64'(st_stall), 64'd0);

      // Table: R2 R3 R7 R8 R9 R11
      for (int i = 0; i < NVEC; i++) begin
         ld_valid = (TBL[i].kind == 2'd1);
         st_valid = (TBL[i].kind == 2'd2);
         ld_line  = TBL[i].line;
         st_line  = TBL[i].line;
         ld_word  = TBL[i].word;
         ld_ptag  = TBL[i].tag;
         #1;
         if (TBL[i].kind == 2'd1)
            chk(ld_stall == TBL[i].stall, $sformatf("table row %0d load stall", i),
                64'(ld_stall), 64'(TBL[i].stall));
         else
            chk(st_stall == TBL[i].stall, $sformatf("table row %0d store stall", i),
                64'(st_stall), 64'(TBL[i].stall));
         @(negedge clk);
         idle_inputs();
         chk(mem_req_valid == TBL[i].req, $sformatf("table row %0d request", i),
             64'(mem_req_valid), 64'(TBL[i].req));
         if (TBL[i].req) begin
            chk(mem_req_id == TBL[i].id, $sformatf("table row %0d id", i),
                64'(mem_req_id), 64'(TBL[i].id));
            chk(mem_req_line == TBL[i].line, $sformatf("table row %0d line", i),
                64'(mem_req_line), 64'(TBL[i].line));
         end
      end

      // Fill entry 0: slots word1 tag1, word3 tag2
      send_fill(2'd0, 32'hA000_0000);
      ld_valid = 1'b1; ld_line = 16'h0100; ld_word = 2'd0; ld_ptag = 6'd10;
      st_valid = 1'b1; st_line = 16'h0100;
      #1;
      chk(ld_stall == 1'b1, "R10 load to line in delivery", 64'(ld_stall), 64'd1);
      chk(st_stall == 1'b1, "R7 store during delivery", 64'(st_stall), 64'd1);
      chk(resp_valid == 1'b0, "R4 no response at capture", 64'(resp_valid), 64'd0);
      @(negedge clk);
      idle_inputs();
      chk(mem_req_valid == 1'b0, "R10 no request", 64'(mem_req_valid), 64'd0);
      expect_resp("R4 first word", 2'd1, 6'd1, 32'hA000_0000);
      @(negedge clk);
      expect_resp("R5 second word", 2'd3, 6'd2, 32'hA000_0000);
      @(negedge clk);
      chk(resp_valid == 1'b0, "R4 burst ends", 64'(resp_valid), 64'd0);
      st_valid = 1'b1; st_line = 16'h0100;
      #1;
      chk(st_stall == 1'b0, "R6 store after free", 64'(st_stall), 64'd0);
      st_valid = 1'b0;
      ld_valid = 1'b1; ld_line = 16'h0500; ld_word = 2'd2; ld_ptag = 6'd9;
      #1;
      chk(ld_stall == 1'b0, "R6 reallocation accepted", 64'(ld_stall), 64'd0);
      @(negedge clk);
      idle_inputs();
      chk(mem_req_valid == 1'b1, "R6 request", 64'(mem_req_valid), 64'd1);
      chk(mem_req_id == 2'd0, "R6 reused index", 64'(mem_req_id), 64'd0);

      // Fill entry 2: word2 tag5 then word0 tag8 -> ascending order
      repeat (2) @(negedge clk);
      send_fill(2'd2, 32'hB000_0000);
      @(negedge clk);
      expect_resp("R5 R11 word0 first", 2'd0, 6'd8, 32'hB000_0000);
      @(negedge clk);
      expect_resp("R5 word2 second", 2'd2, 6'd5, 32'hB000_0000);
      @(negedge clk);
      chk(resp_valid == 1'b0, "R4 burst of two ends", 64'(resp_valid), 64'd0);

      // R2 lowest free index is now 2
      ld_valid = 1'b1; ld_line = 16'h0600; ld_word = 2'd1; ld_ptag = 6'd11;
      @(negedge clk);
      idle_inputs();
      chk(mem_req_valid == 1'b1, "R2 new primary", 64'(mem_req_valid), 64'd1);
      chk(mem_req_id == 2'd2, "R2 lowest free", 64'(mem_req_id), 64'd2);

      // Fill entry 0 again: single slot word2 tag9
      repeat (2) @(negedge clk);
      send_fill(2'd0, 32'hC000_0000);
      @(negedge clk);
      expect_resp("R4 single slot", 2'd2, 6'd9, 32'hC000_0000);
      @(negedge clk);
      chk(resp_valid == 1'b0, "R4 single burst ends", 64'(resp_valid), 64'd0);
      st_valid = 1'b1; st_line = 16'h0500;
      #1;
      chk(st_stall == 1'b0, "R6 line freed", 64'(st_stall), 64'd0);
      st_line = 16'h0600;
      #1;
      chk(st_stall == 1'b1, "R7 other entry still pending", 64'(st_stall), 64'd1);
      @(negedge clk);
      idle_inputs();

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule